// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer N and emits one single-cycle pulse per N input cycles, for use as the feedback input of a phase detector. Internally it models a dual-modulus prescaler that divides by either P (32) or P+1 (33), steered by two counters. A 5-bit swallow count A and a 10-bit main count B set the ratio N = 32·B + A. Within one output period the prescaler runs at 33 for its first A cycles and at 32 for the remaining B−A cycles.

The A and B values are captured only when a new output period begins, so software may rewrite them at any time without producing a corrupted period. While the divider is disabled or held, every counter sits at its zero load point. On release, counting restarts from zero, so the first output pulse has a fixed phase relative to the release. A captured setting with B below 3 or B below A raises an error output and keeps the divider held until a legal setting is captured.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While running with a legal captured setting, `div_pulse_o` is high for exactly one input cycle out of every N = 32·B + A input cycles, for any legal setting from the smallest ratio (B=3, A=0, N=96) up to the largest (B=1023, A=31, N=32767).
- R2: `mod_hi_o` is high during the first 33·A input cycles of each output period (the prescaler at modulus 33) and low for the remaining 32·(B−A) cycles; with A=0 it never rises.
- R3: `swallow_i` and `main_i` are captured on the clock edge that ends an output period, or on any edge while the divider is not running; a change in the middle of a period does not alter that period's length.
- R4: `cfg_err_o` is high whenever the captured B is below 3 or the captured B is below the captured A; while it is high, `div_pulse_o` and `mod_hi_o` stay low and the counters stay at zero.
- R5: While `en_i` is low or `hold_i` is high, no pulse is produced and the counters are held at zero; after release, the first pulse comes in the N-th input cycle counted from the first running cycle.
- R6: After reset, `div_pulse_o` and `mod_hi_o` are low and `cfg_err_o` is high (the captured setting resets to zero) until a legal setting is captured.
- R7: Ratios below 992 work whenever B ≥ 3 and B ≥ A (for example B=3, A=3 gives 99).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock being divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Divider enable; low holds all counters at zero |
| hold_i | input | 1 | Counter hold; high holds all counters at zero |
| swallow_i | input | 5 | Swallow count A (cycles at modulus 33) |
| main_i | input | 10 | Main count B (prescaler cycles per output period) |
| div_pulse_o | output | 1 | Single-cycle divided output pulse |
| mod_hi_o | output | 1 | High while the prescaler divides by 33 |
| cfg_err_o | output | 1 | Captured setting is illegal; divider held |

## Verification
All three outputs are combinational decodes of registered state, so each is due in the same input cycle as the state it reflects: the first pulse after release comes in the N-th running cycle, a setting written while the divider is idle is captured on the next edge, and an error is visible one cycle after the illegal setting is captured. The bench drives inputs one nanosecond after the rising edge, keeps a behavioural model of the period count and captured setting that steps on the rising edge, and compares every output on the falling edge. Interval checks count falling edges from a release or from the previous pulse, so fixing an illegal setting while running costs exactly one extra capture cycle (N+1).

// File: rtl/psdiv_pkg.sv
package psdiv_pkg;
  localparam int unsigned PRESCALE_DEF = 32;
  localparam int unsigned SWALLOW_W_DEF = 5;
  localparam int unsigned MAIN_W_DEF = 10;
  localparam int unsigned MAIN_MIN_DEF = 3;
endpackage

// File: rtl/psdiv_cfg_capture.sv
module psdiv_cfg_capture #(
  parameter int unsigned A_W = psdiv_pkg::SWALLOW_W_DEF,
  parameter int unsigned B_W = psdiv_pkg::MAIN_W_DEF,
  parameter int unsigned B_MIN = psdiv_pkg::MAIN_MIN_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [A_W-1:0] a_q_o,
  output logic [B_W-1:0] b_q_o,
  output logic           err_o
);
  localparam logic [B_W-1:0] BMIN = B_W'(B_MIN);

  logic [A_W-1:0] a_q, a_d;
  logic [B_W-1:0] b_q, b_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (load_i) begin
      a_d = a_i;
      b_d = b_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign a_q_o = a_q;
  assign b_q_o = b_q;
  assign err_o = (b_q < BMIN) || (b_q < B_W'(a_q));

  // R3: the captured setting only moves on a capture edge
  p_cfg_steady_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/psdiv_prescaler.sv
module psdiv_prescaler #(
  parameter int unsigned P = psdiv_pkg::PRESCALE_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic mod_hi_i,
  output logic wrap_o
);
  localparam int unsigned PC_W = $clog2(P + 1);
  localparam logic [PC_W-1:0] LAST_LO = PC_W'(P - 1);
  localparam logic [PC_W-1:0] LAST_HI = PC_W'(P);

  logic [PC_W-1:0] pc_q, pc_d;
  logic            wrap;

  always_comb begin
    wrap = run_i && (pc_q == (mod_hi_i ? LAST_HI : LAST_LO));
    if (!run_i || wrap) pc_d = '0;
    else                pc_d = pc_q + PC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign wrap_o = wrap;

  // R5: an idle cycle leaves the prescaler at its load point
  p_restart_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pc_q == '0));
endmodule

// File: rtl/psdiv_main_counter.sv
module psdiv_main_counter #(
  parameter int unsigned A_W = psdiv_pkg::SWALLOW_W_DEF,
  parameter int unsigned B_W = psdiv_pkg::MAIN_W_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           wrap_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic           mod_hi_o,
  output logic           term_o
);
  logic [B_W-1:0] bc_q, bc_d;
  logic           at_end;

  always_comb begin
    at_end = (bc_q == (b_i - B_W'(1)));
    if (!run_i)                bc_d = '0;
    else if (wrap_i && at_end) bc_d = '0;
    else if (wrap_i)           bc_d = bc_q + B_W'(1);
    else                       bc_d = bc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bc_q <= '0;
    else         bc_q <= bc_d;
  end

  assign mod_hi_o = run_i && (bc_q < B_W'(a_i));
  assign term_o   = wrap_i && at_end;

  // R1: the period end is a single-cycle event
  p_one_shot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |=> !term_o);
  // R2: the modulus choice only moves on a prescaler wrap
  p_mod_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap_i) |=> (!run_i || $stable(bc_q)));
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
  parameter int unsigned P     = psdiv_pkg::PRESCALE_DEF,
  parameter int unsigned A_W   = psdiv_pkg::SWALLOW_W_DEF,
  parameter int unsigned B_W   = psdiv_pkg::MAIN_W_DEF,
  parameter int unsigned B_MIN = psdiv_pkg::MAIN_MIN_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           hold_i,
  input  logic [A_W-1:0] swallow_i,
  input  logic [B_W-1:0] main_i,
  output logic           div_pulse_o,
  output logic           mod_hi_o,
  output logic           cfg_err_o
);
  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  logic           err, run, load, wrap, mod_hi, term;

  assign run  = en_i && !hold_i && !err;
  assign load = !run || term;

  psdiv_cfg_capture #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .a_i(swallow_i), .b_i(main_i),
    .a_q_o(a_q), .b_q_o(b_q), .err_o(err)
  );

  psdiv_prescaler #(.P(P)) u_psc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run),
    .mod_hi_i(mod_hi), .wrap_o(wrap)
  );

  psdiv_main_counter #(.A_W(A_W), .B_W(B_W)) u_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .wrap_i(wrap),
    .a_i(a_q), .b_i(b_q), .mod_hi_o(mod_hi), .term_o(term)
  );

  assign div_pulse_o = term;
  assign mod_hi_o    = mod_hi;
  assign cfg_err_o   = err;

  // R4: an illegal captured setting keeps the outputs quiet
  p_err_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!div_pulse_o && !mod_hi_o));
  // R5: no pulse while disabled or held
  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || hold_i) |-> !div_pulse_o);
endmodule

// File: tb/pulse_swallow_divider_test.sv
`timescale 1ns/1ps
module pulse_swallow_divider_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       hold = 1'b1;
  logic [4:0] sw = '0;
  logic [9:0] mn = '0;
  logic       pulse, modhi, err;

  int checks = 0;
  int fails = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_swallow_divider uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .hold_i(hold),
    .swallow_i(sw), .main_i(mn),
    .div_pulse_o(pulse), .mod_hi_o(modhi), .cfg_err_o(err)
  );

  // behavioural reference: one integer position within the period
  int m_a = 0, m_b = 0, m_pos = 0;

  function automatic bit m_err();
    return (m_b < 3) || (m_b < m_a);
  endfunction
  function automatic bit m_run();
    return en && !hold && !m_err();
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_pos = 0;
    end else if (!m_run() || m_pos == 32 * m_b + m_a - 1) begin
      m_pos = 0; m_a = int'(sw); m_b = int'(mn);
    end else begin
      m_pos = m_pos + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      automatic bit e_p = m_run() && (m_pos == 32 * m_b + m_a - 1);
      automatic bit e_m = m_run() && (m_pos < 33 * m_a);
      automatic bit e_e = m_err();
      chk(pulse == e_p, "R1 div_pulse_o", int'(pulse), int'(e_p));
      chk(modhi == e_m, "R2 mod_hi_o", int'(modhi), int'(e_m));
      chk(err == e_e, "R4 cfg_err_o", int'(err), int'(e_e));
    end
  end

  task automatic drive(input bit e, input bit h, input int a, input int b);
    @(posedge clk); #1;
    en = e; hold = h; sw = 5'(a); mn = 10'(b);
  endtask

  // counts falling edges up to and including the one that shows a pulse
  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulse && n < 40000 && !done);
  endtask

  task automatic period(input int a, input int b, input int exp, input string tag);
    int n;
    wait_pulse(n);
    chk(n == exp, tag, n, exp);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, seen;
    repeat (3) @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    // R6: reset state
    chk(pulse == 1'b0, "R6 pulse after reset", int'(pulse), 0);
    chk(modhi == 1'b0, "R6 mod after reset", int'(modhi), 0);
    chk(err == 1'b1, "R6 err after reset", int'(err), 1);
    cmp_on = 1'b1;

    // R1 R2: A=5 B=10 -> 325, three periods
    drive(1, 1, 5, 10);
    drive(1, 0, 5, 10);
    period(5, 10, 325, "R5 first pulse after release");
    period(5, 10, 325, "R1 period 325");
    // R2: count modulus-high cycles over one period
    seen = 0; n = 0;
    do begin @(negedge clk); n++; if (modhi) seen++; end while (!pulse && n < 40000);
    chk(seen == 165, "R2 mod-high cycles A=5", seen, 165);

    // R3: mid-period reprogramming
    repeat (100) @(negedge clk);
    drive(1, 0, 2, 6);
    period(5, 10, 225, "R3 current period kept");
    period(2, 6, 194, "R3 new setting next period");

    // R7: small ratios
    drive(1, 1, 3, 3);
    drive(1, 0, 3, 3);
    period(3, 3, 99, "R7 B=A=3 ratio 99");
    period(3, 3, 99, "R7 ratio 99 repeat");
    drive(1, 1, 0, 3);
    drive(1, 0, 0, 3);
    period(0, 3, 96, "R1 minimum ratio 96");
    seen = 0; n = 0;
    do begin @(negedge clk); n++; if (modhi) seen++; end while (!pulse && n < 40000);
    chk(seen == 0, "R2 A=0 never high", seen, 0);
    drive(1, 1, 31, 31);
    drive(1, 0, 31, 31);
    period(31, 31, 1023, "R7 A=B=31 ratio 1023");

    // R5: hold mid-period then restart from zero
    repeat (300) @(negedge clk);
    drive(1, 1, 31, 31);
    seen = 0;
    repeat (50) begin @(negedge clk); if (pulse) seen++; end
    chk(seen == 0, "R5 no pulse while held", seen, 0);
    drive(1, 0, 31, 31);
    period(31, 31, 1023, "R5 restart after hold");
    // R5: enable low behaves the same
    repeat (40) @(negedge clk);
    drive(0, 0, 31, 31);
    seen = 0;
    repeat (40) begin @(negedge clk); if (pulse) seen++; end
    chk(seen == 0, "R5 no pulse while disabled", seen, 0);
    drive(1, 0, 31, 31);
    period(31, 31, 1023, "R5 restart after enable");

    // R4: illegal settings
    drive(1, 1, 0, 2);
    drive(1, 0, 0, 2);
    @(negedge clk);
    chk(err == 1'b1, "R4 err B=2", int'(err), 1);
    seen = 0;
    repeat (300) begin @(negedge clk); if (pulse || modhi) seen++; end
    chk(seen == 0, "R4 quiet while B=2", seen, 0);
    drive(1, 0, 5, 4);
    @(negedge clk); @(negedge clk);
    chk(err == 1'b1, "R4 err B<A", int'(err), 1);
    drive(1, 0, 1, 3);
    period(1, 3, 98, "R4 recovery costs one capture cycle");
    chk(err == 1'b0, "R4 err cleared", int'(err), 0);

    // R1: largest ratio
    drive(1, 1, 31, 1023);
    drive(1, 0, 31, 1023);
    period(31, 1023, 32767, "R1 maximum ratio 32767");

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule